// File: doc/BRIEF.md
# Cached DRAM cycle decoder

This block decodes the strobe pins of a DRAM that keeps one row in an SRAM cache. It runs on a system clock and samples the active-low row strobe, column strobe, write enable, refresh request, chip select and output enable, plus an active-high write select. The inputs pass through a two-flop synchroniser. At every falling edge of the row strobe the block classifies the cycle from the pin levels at that edge. The cycle is one of: internal refresh, read, write (hit or miss), or self-refresh entry. A write in which the column strobe never falls becomes a row-only refresh.

The block keeps two pieces of state. One is a latch holding the row that was last read into the cache. The other is a counter that supplies rows for refresh. From these it drives row and column addresses, a write strobe, a refresh strobe, a cache reload pulse and a cache write strobe toward an array model. It also gates the output drivers for cache reads that need no row strobe. Analog delays are parameters counted in clock cycles. A busy flag stays high while the write-miss output hold-off or the self-refresh exit recovery is running. The block has no streaming data path, so every pin is a plain level or strobe without back-pressure.

Top module: `cdram_decoder`

## Requirements
- R1: A row-strobe fall with refresh request low pulses `arr_rfsh` for one cycle, with `arr_row` equal to the refresh counter. The counter (0 after reset) advances by one when the row strobe rises.
- R2: A row-strobe fall with `wr_sel`=1 and column strobe, write enable and refresh request all high starts a write cycle, which compares the row on `addr` against the last-read-row latch. On a hit, each write drives `arr_row` = that row and `arr_col` = the column captured at the latest column-strobe fall, and raises `cache_wr` together with `arr_wr`.
- R3: A row-strobe fall with `wr_sel`=0 and refresh request high is a read. If the row differs from the latch, or the latch has never been loaded, the latch takes the row and `cache_load` pulses once with `arr_row` set to it. A read of the latched row gives no pulse.
- R4: On a write miss, `arr_wr` still writes the array, but `cache_wr` stays low and the latch (`cache_row`) is unchanged.
- R5: `arr_wr` is high only while both the column strobe and write enable are low, after a column-strobe fall within the current write cycle.
- R6: A write cycle that ends without any column-strobe fall pulses `arr_rfsh` once, with `arr_row` set to the addressed row. It writes nothing and leaves the latch unchanged.
- R7: During a write-miss cycle, `out_en` is low whatever the levels of select and output enable. After the row strobe rises, `busy` stays high and `out_en` stays low for exactly WM_HOLD cycles.
- R8: A row-strobe fall with select, `wr_sel`, refresh request and write enable high and the column strobe low raises `selfref` until the row strobe rises. `busy` is then high for exactly SR_REC cycles. Row-strobe falls that arrive while `busy` is high are ignored.
- R9: While `selfref` is high, `arr_rfsh` pulses every SR_PERIOD cycles with `arr_row` equal to the refresh counter, and the counter advances after each pulse.
- R10: With select and output enable low and no write miss, self-refresh or busy, `out_en` is high, `cache_row` shows the latch and `cache_col` shows the column bits of `addr`, with no row strobe needed.
- R11: `standby` is high when select is high and no cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| rfsh_n | input | 1 | Internal refresh request, active low |
| sel_n | input | 1 | Chip select, active low; high means standby |
| oe_n | input | 1 | Output enable, active low |
| wr_sel | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | ROW_W | Multiplexed row/column address |
| arr_row | output | ROW_W | Row presented to the array |
| arr_col | output | COL_W | Column presented to the array |
| arr_wr | output | 1 | Array write strobe |
| arr_rfsh | output | 1 | Array row refresh pulse |
| cache_load | output | 1 | Reload cache from `arr_row` |
| cache_wr | output | 1 | Write cache at `arr_col` |
| cache_row | output | ROW_W | Last-read-row latch |
| cache_col | output | COL_W | Column for strobe-free cache reads |
| out_en | output | 1 | Data output driver enable |
| busy | output | 1 | A hold-off or recovery delay is running |
| selfref | output | 1 | Self-refresh mode active |
| standby | output | 1 | Deselected and idle |

## Verification
The bench builds the block with WM_HOLD=5, SR_REC=6 and SR_PERIOD=8. Both delay windows can therefore be counted cycle by cycle. A twenty-cycle self-refresh interval contains exactly two periodic refresh pulses, so the refresh counter's position afterwards is known exactly. The short recovery window also leaves room for a refresh request to arrive in the middle of it and be shown to be ignored.

// File: rtl/cdram_pkg.sv
package cdram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IREF,
    ST_READ,
    ST_WRITE,
    ST_SELF,
    ST_HOLD,
    ST_RECOV
  } cyc_st_t;
endpackage

// File: rtl/cdram_sync.sv
module cdram_sync #(
  parameter int W = 7,
  parameter int EDGE_W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o,
  output logic [EDGE_W-1:0] prv_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= in_i;
      sync_q <= meta_q;
    end
  end
  assign lvl_o = sync_q;

  // extra stage only on the bits whose edges are needed
  for (genvar i = 0; i < EDGE_W; i++) begin : g_edge
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL[i];
      else        prev_q <= sync_q[i];
    end
    assign prv_o[i] = prev_q;
  end
endmodule

// File: rtl/cdram_rows.sv
module cdram_rows #(
  parameter int ROW_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrr_ld,
  input  logic [ROW_W-1:0] lrr_d,
  input  logic rcnt_inc,
  output logic [ROW_W-1:0] lrr_o,
  output logic lrr_vld_o,
  output logic [ROW_W-1:0] rcnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrr_o     <= '0;
      lrr_vld_o <= 1'b0;
      rcnt_o    <= '0;
    end else begin
      if (lrr_ld) begin
        lrr_o     <= lrr_d;
        lrr_vld_o <= 1'b1;
      end
      if (rcnt_inc) rcnt_o <= rcnt_o + ROW_W'(1);
    end
  end
endmodule

// File: rtl/cdram_seq.sv
module cdram_seq
  import cdram_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 9,
  parameter int WM_HOLD = 4,
  parameter int SR_REC = 12,
  parameter int SR_PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_fall,
  input  logic row_rise,
  input  logic col_fall,
  input  logic col_s,
  input  logic we_s,
  input  logic rfsh_s,
  input  logic sel_s,
  input  logic oe_s,
  input  logic wr_s,
  input  logic [ROW_W-1:0] addr_s,
  input  logic [ROW_W-1:0] lrr,
  input  logic lrr_vld,
  input  logic [ROW_W-1:0] rcnt,
  output logic lrr_ld,
  output logic rcnt_inc,
  output logic [ROW_W-1:0] arr_row,
  output logic [COL_W-1:0] arr_col,
  output logic arr_rfsh,
  output logic arr_wr,
  output logic cache_load,
  output logic cache_wr,
  output logic out_en,
  output logic busy,
  output logic selfref,
  output logic standby
);
  localparam int MAXD = (WM_HOLD > SR_REC) ? WM_HOLD : SR_REC;
  localparam int DW = $clog2(MAXD + 1);
  localparam int TW = $clog2(SR_PERIOD + 1);

  cyc_st_t st;
  logic wr_hit, col_ok;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] tmr;
  logic hit_c, tick_c, self_c, write_c, read_c;

  assign hit_c   = lrr_vld && (addr_s == lrr);
  assign self_c  = sel_s && wr_s && we_s && !col_s;
  assign write_c = wr_s && col_s && we_s;
  assign read_c  = !wr_s;
  assign tick_c  = (st == ST_SELF) && !row_rise && (tmr == TW'(SR_PERIOD - 1));

  assign lrr_ld   = (st == ST_IDLE) && row_fall && rfsh_s && read_c && !hit_c;
  assign rcnt_inc = ((st == ST_IREF) && row_rise) || tick_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      wr_hit     <= 1'b0;
      col_ok     <= 1'b0;
      dcnt       <= '0;
      tmr        <= '0;
      arr_row    <= '0;
      arr_col    <= '0;
      arr_rfsh   <= 1'b0;
      cache_load <= 1'b0;
    end else begin
      arr_rfsh   <= 1'b0;
      cache_load <= 1'b0;
      unique case (st)
        ST_IDLE: if (row_fall) begin
          if (!rfsh_s) begin
            st       <= ST_IREF;
            arr_rfsh <= 1'b1;
            arr_row  <= rcnt;
          end else if (self_c) begin
            st  <= ST_SELF;
            tmr <= '0;
          end else if (write_c) begin
            st      <= ST_WRITE;
            wr_hit  <= hit_c;
            col_ok  <= 1'b0;
            arr_row <= addr_s;
          end else if (read_c) begin
            st         <= ST_READ;
            arr_row    <= addr_s;
            cache_load <= !hit_c;
          end
        end
        ST_IREF, ST_READ: if (row_rise) st <= ST_IDLE;
        ST_WRITE: begin
          if (col_fall) begin
            col_ok  <= 1'b1;
            arr_col <= addr_s[COL_W-1:0];
          end
          if (row_rise) begin
            if (!col_ok && !col_fall) arr_rfsh <= 1'b1;
            if (wr_hit) st <= ST_IDLE;
            else begin
              st   <= ST_HOLD;
              dcnt <= DW'(WM_HOLD - 1);
            end
          end
        end
        ST_SELF: begin
          if (row_rise) begin
            st   <= ST_RECOV;
            dcnt <= DW'(SR_REC - 1);
          end else if (tick_c) begin
            tmr      <= '0;
            arr_rfsh <= 1'b1;
            arr_row  <= rcnt;
          end else begin
            tmr <= tmr + TW'(1);
          end
        end
        ST_HOLD, ST_RECOV: begin
          if (dcnt == '0) st <= ST_IDLE;
          else            dcnt <= dcnt - DW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign arr_wr   = (st == ST_WRITE) && col_ok && !col_s && !we_s;
  assign cache_wr = arr_wr && wr_hit;
  assign busy     = (st == ST_HOLD) || (st == ST_RECOV);
  assign selfref  = (st == ST_SELF);
  assign standby  = sel_s && (st == ST_IDLE);
  assign out_en   = !sel_s && !oe_s && !busy && !selfref
                  && !((st == ST_WRITE) && !wr_hit);
endmodule

// File: rtl/cdram_decoder.sv
module cdram_decoder #(
  parameter int ROW_W = 11,
  parameter int COL_W = 9,
  parameter int WM_HOLD = 4,
  parameter int SR_REC = 12,
  parameter int SR_PERIOD = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_n,
  input  logic col_n,
  input  logic we_n,
  input  logic rfsh_n,
  input  logic sel_n,
  input  logic oe_n,
  input  logic wr_sel,
  input  logic [ROW_W-1:0] addr,
  output logic [ROW_W-1:0] arr_row,
  output logic [COL_W-1:0] arr_col,
  output logic arr_wr,
  output logic arr_rfsh,
  output logic cache_load,
  output logic cache_wr,
  output logic [ROW_W-1:0] cache_row,
  output logic [COL_W-1:0] cache_col,
  output logic out_en,
  output logic busy,
  output logic selfref,
  output logic standby
);
  localparam int NCTL = 7;
  localparam int NEDGE = 2;

  logic [NCTL-1:0] ctl_lvl;
  logic [NEDGE-1:0] ctl_prv;
  logic [ROW_W-1:0] addr_m, addr_s;
  logic row_fall, row_rise, col_fall;
  logic lrr_ld, lrr_vld, rcnt_inc;
  logic [ROW_W-1:0] rcnt;

  // bit 0 row strobe, bit 1 column strobe: the two that need edges
  cdram_sync #(.W(NCTL), .EDGE_W(NEDGE), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .in_i({oe_n, sel_n, wr_sel, rfsh_n, we_n, col_n, row_n}),
    .lvl_o(ctl_lvl), .prv_o(ctl_prv)
  );

  // address follows the same two-stage latency as the strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_m <= '0;
      addr_s <= '0;
    end else begin
      addr_m <= addr;
      addr_s <= addr_m;
    end
  end

  assign row_fall = ctl_prv[0] && !ctl_lvl[0];
  assign row_rise = !ctl_prv[0] && ctl_lvl[0];
  assign col_fall = ctl_prv[1] && !ctl_lvl[1];

  cdram_rows #(.ROW_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n),
    .lrr_ld(lrr_ld), .lrr_d(addr_s), .rcnt_inc(rcnt_inc),
    .lrr_o(cache_row), .lrr_vld_o(lrr_vld), .rcnt_o(rcnt)
  );

  cdram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .WM_HOLD(WM_HOLD),
    .SR_REC(SR_REC), .SR_PERIOD(SR_PERIOD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .row_fall(row_fall), .row_rise(row_rise), .col_fall(col_fall),
    .col_s(ctl_lvl[1]), .we_s(ctl_lvl[2]), .rfsh_s(ctl_lvl[3]),
    .wr_s(ctl_lvl[4]), .sel_s(ctl_lvl[5]), .oe_s(ctl_lvl[6]),
    .addr_s(addr_s), .lrr(cache_row), .lrr_vld(lrr_vld), .rcnt(rcnt),
    .lrr_ld(lrr_ld), .rcnt_inc(rcnt_inc),
    .arr_row(arr_row), .arr_col(arr_col), .arr_rfsh(arr_rfsh),
    .arr_wr(arr_wr), .cache_load(cache_load), .cache_wr(cache_wr),
    .out_en(out_en), .busy(busy), .selfref(selfref), .standby(standby)
  );

  assign cache_col = addr_s[COL_W-1:0];
endmodule

// File: rtl/cdram_decoder_chk.sv
module cdram_decoder_chk #(
  parameter int ROW_W = 11,
  parameter int COL_W = 9,
  parameter int WM_HOLD = 4,
  parameter int SR_REC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic arr_wr,
  input logic arr_rfsh,
  input logic cache_load,
  input logic [COL_W-1:0] arr_col,
  input logic [ROW_W-1:0] cache_row,
  input logic out_en,
  input logic busy,
  input logic selfref
);
  localparam int MAXD = (WM_HOLD > SR_REC) ? WM_HOLD : SR_REC;
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else        busy_run <= busy ? busy_run + 1 : 0;
  end

  a_r6_single_array_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_wr, arr_rfsh, cache_load}));
  a_r2_col_held: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && $past(arr_wr)) |-> $stable(arr_col));
  a_r3_latch_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cache_row) |-> cache_load);
  a_r7_busy_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!arr_wr && !cache_load));
  a_r8_exit_to_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(selfref) |-> busy);
  a_r9_self_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    selfref |-> (!out_en && !arr_wr));
  a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= MAXD);
endmodule

bind cdram_decoder cdram_decoder_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .WM_HOLD(WM_HOLD), .SR_REC(SR_REC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .arr_wr(arr_wr), .arr_rfsh(arr_rfsh),
  .cache_load(cache_load), .arr_col(arr_col), .cache_row(cache_row),
  .out_en(out_en), .busy(busy), .selfref(selfref)
);

// File: tb/cdram_decoder_tb.sv
module cdram_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 11;
  localparam int COL_W = 9;
  localparam int WM_HOLD = 5;
  localparam int SR_REC = 6;
  localparam int SR_PERIOD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_n = 1'b1, col_n = 1'b1, we_n = 1'b1, rfsh_n = 1'b1;
  logic sel_n = 1'b1, oe_n = 1'b1, wr_sel = 1'b0;
  logic [ROW_W-1:0] addr = '0;
  logic [ROW_W-1:0] arr_row, cache_row;
  logic [COL_W-1:0] arr_col, cache_col;
  logic arr_wr, arr_rfsh, cache_load, cache_wr, out_en, busy, selfref, standby;

  int n_chk = 0, n_fail = 0;
  int n_rfsh, n_wr, n_cwr, n_load, n_busy, n_oeb;
  int last_rfsh_row, last_load_row, last_wr_row, last_col;
  logic mid_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdram_decoder #(
    .ROW_W(ROW_W), .COL_W(COL_W), .WM_HOLD(WM_HOLD),
    .SR_REC(SR_REC), .SR_PERIOD(SR_PERIOD)
  ) dut_i (.*);

  always @(negedge clk) begin
    if (arr_rfsh) begin n_rfsh++; last_rfsh_row = arr_row; end
    if (arr_wr) begin n_wr++; last_wr_row = arr_row; last_col = arr_col; end
    if (cache_wr) n_cwr++;
    if (cache_load) begin n_load++; last_load_row = arr_row; end
    if (busy) n_busy++;
    if (busy && out_en) n_oeb++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr();
    n_rfsh = 0; n_wr = 0; n_cwr = 0; n_load = 0; n_busy = 0; n_oeb = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_iref();
    rfsh_n = 1'b0; step(1);
    row_n = 1'b0; step(4);
    row_n = 1'b1; step(1);
    rfsh_n = 1'b1; step(4);
  endtask

  task automatic do_read(input int row);
    addr = ROW_W'(row); wr_sel = 1'b0; step(1);
    row_n = 1'b0; step(4);
    row_n = 1'b1; step(4);
  endtask

  task automatic do_write(input int row, input int col, input bit tog, input bit wen);
    addr = ROW_W'(row); wr_sel = 1'b1; col_n = 1'b1; we_n = 1'b1; step(1);
    row_n = 1'b0; step(4);
    if (tog) begin
      addr = ROW_W'(col); col_n = 1'b0;
      if (wen) we_n = 1'b0;
    end
    step(4);
    mid_oe = out_en;
    we_n = 1'b1; col_n = 1'b1; step(3);
    row_n = 1'b1; step(WM_HOLD + 8);
    wr_sel = 1'b0;
  endtask

  task automatic t_reset();
    step(3);
    chk(busy == 0, "R8", "busy after reset", busy, 0);
    chk(selfref == 0, "R8", "selfref after reset", selfref, 0);
    chk(arr_wr == 0, "R5", "arr_wr after reset", arr_wr, 0);
    chk(standby == 1, "R11", "standby after reset", standby, 1);
  endtask

  task automatic t_iref();
    clr(); do_iref();
    chk(n_rfsh == 1, "R1", "first refresh pulses", n_rfsh, 1);
    chk(last_rfsh_row == 0, "R1", "first refresh row", last_rfsh_row, 0);
    clr(); do_iref();
    chk(last_rfsh_row == 1, "R1", "second refresh row", last_rfsh_row, 1);
  endtask

  task automatic t_read();
    sel_n = 1'b0;
    clr(); do_read('h123);
    chk(n_load == 1, "R3", "miss load pulses", n_load, 1);
    chk(last_load_row == 'h123, "R3", "load row", last_load_row, 'h123);
    chk(cache_row == 'h123, "R3", "latch row", cache_row, 'h123);
    clr(); do_read('h123);
    chk(n_load == 0, "R3", "hit load pulses", n_load, 0);
  endtask

  task automatic t_write_hit();
    clr(); do_write('h123, 'h45, 1'b1, 1'b1);
    chk(n_wr > 0, "R2", "hit write strobes", n_wr, 1);
    chk(n_cwr == n_wr, "R2", "hit cache writes", n_cwr, n_wr);
    chk(last_col == 'h45, "R2", "write column", last_col, 'h45);
    chk(last_wr_row == 'h123, "R2", "write row", last_wr_row, 'h123);
  endtask

  task automatic t_no_we();
    clr(); do_write('h123, 'h46, 1'b1, 1'b0);
    chk(n_wr == 0, "R5", "writes without we", n_wr, 0);
    chk(n_rfsh == 0, "R5", "refresh with column toggled", n_rfsh, 0);
  endtask

  task automatic t_write_miss();
    oe_n = 1'b0;
    clr(); do_write('h200, 'h10, 1'b1, 1'b1);
    chk(n_wr > 0, "R4", "miss array writes", n_wr, 1);
    chk(n_cwr == 0, "R4", "miss cache writes", n_cwr, 0);
    chk(cache_row == 'h123, "R4", "latch after miss", cache_row, 'h123);
    chk(mid_oe == 0, "R7", "out_en during miss", mid_oe, 0);
    chk(n_busy == WM_HOLD, "R7", "hold-off cycles", n_busy, WM_HOLD);
    chk(n_oeb == 0, "R7", "out_en while busy", n_oeb, 0);
    chk(out_en == 1, "R7", "out_en after hold-off", out_en, 1);
    oe_n = 1'b1;
  endtask

  task automatic t_row_only();
    clr(); do_write('h300, 0, 1'b0, 1'b0);
    chk(n_rfsh == 1, "R6", "row-only refresh pulses", n_rfsh, 1);
    chk(last_rfsh_row == 'h300, "R6", "row-only refresh row", last_rfsh_row, 'h300);
    chk(n_wr == 0, "R6", "row-only writes", n_wr, 0);
    chk(cache_row == 'h123, "R6", "latch after row-only", cache_row, 'h123);
  endtask

  task automatic t_self();
    sel_n = 1'b1; wr_sel = 1'b1; we_n = 1'b1; rfsh_n = 1'b1; col_n = 1'b0; step(1);
    clr();
    row_n = 1'b0; step(10);
    chk(selfref == 1, "R8", "selfref during mode", selfref, 1);
    step(10);
    row_n = 1'b1;
    chk(n_rfsh == 2, "R9", "self refresh pulses", n_rfsh, 2);
    chk(last_rfsh_row == 3, "R9", "last self refresh row", last_rfsh_row, 3);
    clr();
    step(2);
    rfsh_n = 1'b0; row_n = 1'b0; step(2);
    row_n = 1'b1; step(1);
    rfsh_n = 1'b1; col_n = 1'b1; wr_sel = 1'b0; step(15);
    chk(selfref == 0, "R8", "selfref after exit", selfref, 0);
    chk(n_busy == SR_REC, "R8", "recovery cycles", n_busy, SR_REC);
    chk(n_rfsh == 0, "R8", "refresh during recovery", n_rfsh, 0);
    clr(); do_iref();
    chk(last_rfsh_row == 4, "R1", "refresh row after self", last_rfsh_row, 4);
  endtask

  task automatic t_cache_read();
    sel_n = 1'b0; oe_n = 1'b0; addr = ROW_W'('h0AB); step(4);
    chk(out_en == 1, "R10", "out_en strobe-free read", out_en, 1);
    chk(cache_col == 'h0AB, "R10", "cache column", cache_col, 'h0AB);
    chk(cache_row == 'h123, "R10", "cache row", cache_row, 'h123);
  endtask

  task automatic t_standby();
    sel_n = 1'b1; step(4);
    chk(standby == 1, "R11", "standby when deselected", standby, 1);
    chk(out_en == 0, "R10", "out_en when deselected", out_en, 0);
    sel_n = 1'b0; step(4);
    chk(standby == 0, "R11", "standby when selected", standby, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_iref();
    t_read();
    t_write_hit();
    t_no_we();
    t_write_miss();
    t_row_only();
    t_self();
    t_cache_read();
    t_standby();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule